// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

An 8-bit up-counter advances on a divided version of an input clock-enable tick. A prescaler sits between the tick and the counter and passes on one tick in 1, 4 or 16. The counter is compared with a programmable period register. When the counter already holds the period value, the next increment returns it to zero and produces a one-cycle match pulse. A PWM generator outside this block uses that pulse as its time base.

A 4-bit postscaler counts match events. Once every N of them it sets a sticky interrupt flag. Software reaches the counter, the period register, the control register and the flag through a simple synchronous write port and a combinational read port.

Top module: `pm_timer`

## Requirements
- R1: After reset the counter reads 0x00, the period reads 0xFF, control reads 0x00, the flag is 0 and match_pulse is 0.
- R2: Address 0 is the counter, 1 the period, 2 control and 3 the flag (bit 0). The counter and period are fully readable and writable. Control stores bits 6:0 and reads bit 7 as 0. Control bits 6:3 are the postscale value, bit 2 is the run enable and bits 1:0 are the prescale select.
- R3: On each increment event the counter rises by one. When it equals the period at an increment, it goes to 0x00 instead.
- R4: Prescale select 00 gives one increment per tick, 01 one per 4 ticks, and 10 or 11 one per 16 ticks.
- R5: match_pulse is high for exactly the cycle after an edge on which the counter wrapped to zero.
- R6: With postscale value p, the flag is set on every (p+1)-th match event and rises in the same cycle as that match_pulse.
- R7: While the run enable is 0, ticks are ignored. The counter holds, the prescaler does not advance, and no match or flag set occurs.
- R8: A write to the counter or to control clears the prescale and postscale counts, and no increment happens in that cycle.
- R9: The flag stays set until a write to address 3 loads bit 0. A flag set event in the same cycle as that write wins.
- R10: A write to the period register leaves the prescale and postscale counts and the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counting clock enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| match_pulse | output | 1 | One-cycle period match (PWM time base) |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
Two events can fall in the same cycle: a postscaler flag set and a software write that clears the flag. A counter or control write can likewise land on the edge where a wrap would happen. Both collisions are provoked with period 0, prescale 1:1, postscale 1:1 and a tick on every cycle, because then every cycle sets the flag and any clear write collides. The bench judges the outcome against a register-level model that follows the requirements. Random stimulus with short periods and frequent writes exercises further overlaps of writes and wraps.

// File: rtl/pm_timer.sv
module pm_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       match_pulse,
  output logic       irq_flag
);
  logic [7:0] cnt_q, per_q;
  logic [6:0] ctl_q;
  logic [3:0] pre_q, post_q;
  logic       match_q, flag_q;

  logic       run, wr_cnt, wr_per, wr_ctl, wr_flg, clr_div;
  logic [3:0] pre_lim, post_lim;
  logic       inc, wrap, set_flag;

  assign run      = ctl_q[2];
  assign post_lim = ctl_q[6:3];
  assign pre_lim  = (ctl_q[1:0] == 2'd0) ? 4'd0 :
                    (ctl_q[1:0] == 2'd1) ? 4'd3 : 4'd15;
  assign wr_cnt   = wr_en && addr == 2'd0;
  assign wr_per   = wr_en && addr == 2'd1;
  assign wr_ctl   = wr_en && addr == 2'd2;
  assign wr_flg   = wr_en && addr == 2'd3;
  assign clr_div  = wr_cnt || wr_ctl;

  assign inc      = !clr_div && tick && run && pre_q == pre_lim;
  assign wrap     = inc && cnt_q == per_q;
  assign set_flag = wrap && post_q == post_lim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= 8'h00;
      per_q   <= 8'hFF;
      ctl_q   <= 7'h00;
      pre_q   <= 4'd0;
      post_q  <= 4'd0;
      match_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      match_q <= wrap;
      if (wr_per) per_q <= wdata;
      if (wr_ctl) ctl_q <= wdata[6:0];

      if (clr_div) pre_q <= 4'd0;
      else if (tick && run) pre_q <= (pre_q == pre_lim) ? 4'd0 : pre_q + 4'd1;

      if (wr_cnt) cnt_q <= wdata;
      else if (wrap) cnt_q <= 8'h00;
      else if (inc) cnt_q <= cnt_q + 8'd1;

      if (clr_div) post_q <= 4'd0;
      else if (wrap) post_q <= (post_q == post_lim) ? 4'd0 : post_q + 4'd1;

      if (set_flag) flag_q <= 1'b1;
      else if (wr_flg) flag_q <= wdata[0];
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = cnt_q;
      2'd1:    rdata = per_q;
      2'd2:    rdata = {1'b0, ctl_q};
      default: rdata = {7'd0, flag_q};
    endcase
  end

  assign match_pulse = match_q;
  assign irq_flag    = flag_q;
endmodule

module pm_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic [7:0] rdata,
  input logic [7:0] cnt_q,
  input logic [6:0] ctl_q,
  input logic       match_pulse,
  input logic       irq_flag
);
  // R5
  match_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> cnt_q == 8'h00);
  // R7
  idle_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ctl_q[2]) |-> !match_pulse);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ctl_q[2] && !(wr_en && addr == 2'd0)) |-> $stable(cnt_q));
  // R6
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> match_pulse || $past(wr_en && addr == 2'd3));
  // R9
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_flag) |-> $past(wr_en && addr == 2'd3));
  // R2
  ctl_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 2'd2 |-> !rdata[7]);
endmodule

bind pm_timer pm_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .rdata(rdata),
  .cnt_q(cnt_q), .ctl_q(ctl_q), .match_pulse(match_pulse), .irq_flag(irq_flag)
);

// File: tb/tb_pm_timer.sv
module tb_pm_timer;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic match_pulse, irq_flag;

  pm_timer dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
                .wdata(wdata), .rdata(rdata), .match_pulse(match_pulse), .irq_flag(irq_flag));

  always #5 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;
  string tag = "R3";

  // reference state
  logic [7:0] m_cnt = 8'h00, m_per = 8'hFF;
  logic [6:0] m_ctl = 7'h00;
  int m_pre = 0, m_post = 0;
  logic m_match = 1'b0, m_flag = 1'b0;

  function automatic int ticks_per_inc(input logic [1:0] sel);
    return (sel == 2'd0) ? 1 : (sel == 2'd1) ? 4 : 16;  // R4
  endfunction

  function automatic logic [7:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_cnt;
      2'd1: return m_per;
      2'd2: return {1'b0, m_ctl};
      default: return {7'd0, m_flag};
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic inc = 1'b0, setf = 1'b0, m = 1'b0;
    if (wr_en && (addr == 2'd0 || addr == 2'd2)) begin  // R8
      if (addr == 2'd0) m_cnt = wdata; else m_ctl = wdata[6:0];
      m_pre = 0; m_post = 0;
    end else if (tick && m_ctl[2]) begin                // R7
      if (m_pre == ticks_per_inc(m_ctl[1:0]) - 1) begin m_pre = 0; inc = 1'b1; end
      else m_pre++;
    end
    if (inc) begin                                      // R3
      if (m_cnt == m_per) begin
        m_cnt = 8'h00; m = 1'b1;
        if (m_post == int'(m_ctl[6:3])) begin m_post = 0; setf = 1'b1; end
        else m_post++;
      end else m_cnt = m_cnt + 8'd1;
    end
    if (wr_en && addr == 2'd1) m_per = wdata;           // R10
    if (setf) m_flag = 1'b1;                            // R9
    else if (wr_en && addr == 2'd3) m_flag = wdata[0];
    m_match = m;
  endtask

  task automatic cycle(input logic t, input logic w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    check(tag, {7'd0, match_pulse}, {7'd0, m_match});
    check("R6", {7'd0, irq_flag}, {7'd0, m_flag});
    tick = t; wr_en = w; addr = a; wdata = d;
    #1;
    check((a == 2'd0) ? "R3" : (a == 2'd3) ? "R9" : "R2", rdata, model_read(a));
    model_step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values through the read port
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); addr = a[1:0]; #1;
      check("R1", rdata, (a == 1) ? 8'hFF : 8'h00);
      check("R1", {6'd0, match_pulse, irq_flag}, 8'h00);
    end
    // R7: ticks with run disabled change nothing
    tag = "R7";
    repeat (20) cycle(1'b1, 1'b0, 2'd0, 8'h00);
    // R5/R6: period 2, postscale 1 (every 2nd match), 1:1
    tag = "R5";
    cycle(1'b0, 1'b1, 2'd1, 8'h02);
    cycle(1'b0, 1'b1, 2'd2, {1'b0, 4'd1, 1'b1, 2'd0});
    repeat (14) cycle(1'b1, 1'b0, 2'd0, 8'h00);
    // R4: prescale 1:4 then 1:16 (code 11)
    tag = "R4";
    cycle(1'b0, 1'b1, 2'd2, {1'b0, 4'd0, 1'b1, 2'd1});
    repeat (30) cycle(1'b1, 1'b0, 2'd0, 8'h00);
    cycle(1'b0, 1'b1, 2'd2, {1'b0, 4'd0, 1'b1, 2'd3});
    repeat (100) cycle(1'b1, 1'b0, 2'd0, 8'h00);
    // R10: period write mid-prescale keeps the prescale phase
    tag = "R10";
    repeat (5) cycle(1'b1, 1'b0, 2'd0, 8'h00);
    cycle(1'b1, 1'b1, 2'd1, 8'h01);
    repeat (40) cycle(1'b1, 1'b0, 2'd0, 8'h00);
    // R9: set/clear collision, period 0, 1:1, postscale 1:1
    tag = "R9";
    cycle(1'b0, 1'b1, 2'd1, 8'h00);
    cycle(1'b0, 1'b1, 2'd2, {1'b0, 4'd0, 1'b1, 2'd0});
    repeat (4) cycle(1'b1, 1'b0, 2'd3, 8'h00);
    repeat (4) cycle(1'b1, 1'b1, 2'd3, 8'h00);
    cycle(1'b0, 1'b1, 2'd3, 8'h00);
    cycle(1'b0, 1'b0, 2'd3, 8'h00);
    // R8: counter write on a would-be wrap edge
    tag = "R8";
    cycle(1'b1, 1'b1, 2'd0, 8'h00);
    cycle(1'b1, 1'b1, 2'd0, 8'h05);
    repeat (4) cycle(1'b1, 1'b0, 2'd0, 8'h00);
    // random mix
    tag = "R3";
    for (int i = 0; i < 3000; i++) begin
      logic t, w; logic [1:0] a; logic [7:0] d;
      t = ($urandom % 4) != 0;
      w = ($urandom % 10) == 0;
      a = 2'($urandom % 4);
      d = 8'($urandom);
      if (w && a == 2'd1) d = 8'($urandom % 8);
      if (w && a == 2'd0) d = 8'($urandom % 8);
      if (w && a == 2'd2) d[2] = ($urandom % 8) != 0;
      cycle(t, w, a, d);
    end
    cycle(1'b0, 1'b0, 2'd0, 8'h00);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule